// File: doc/BRIEF.md
# Multi-channel triggered PWM

This block drives several independent pulse-width modulated outputs. Software writes each channel's period count, duty-high count, prescale value and polarity into shadow storage over a simple synchronous register bus. None of these writes reaches the live waveform until a per-channel trigger handshake completes. Software first drops the trigger with the smooth bit set, which keeps the old waveform running. It then keeps the trigger low for a minimum time, raises it with smooth cleared, and holds it high for a minimum time.

The minimum hold time is given in nanoseconds. It is converted into a clock-cycle count from the clock period parameter, and the block checks it in hardware. A rising edge that comes too early is rejected. A high phase that ends too early is also rejected. In both cases the active settings are left untouched. A completed handshake stages the shadow values, and the staged values become active at the next period boundary, so the waveform never shows a partial period. Applying all-zero period, duty and prescale parks the output at its inactive level, and this serves as the disable state.

Top module: `pwm_trig_multi`

## Requirements
- R1: Register addresses are: 0 = control, 1 = prescale, 2+2c = period count of channel c, 3+2c = duty-high count of channel c. Every register reads back the last value written. Any other address reads zero.
- R2: In the control register, channel c has its trigger at bit c, its smooth bit at bit NCH+c and its polarity bit at bit 2·NCH+c, where 1 means inverted. In the prescale register, channel c takes its field from bits [PS_W·c +: PS_W], and each channel uses only its own field.
- R3: With active period P ≥ 1, duty D and prescale S, each period of the output is high for min(D,P)·(S+1) clocks and low for (P−min(D,P))·(S+1) clocks. When D ≥ P the output stays high.
- R4: If the trigger rises after being low for fewer than HOLD_CYC cycles, the transfer is ignored.
- R5: A transfer needs the trigger high with the smooth bit clear. Shadow writes made while the trigger is low, and a trigger pulse made with smooth set, leave the output unchanged.
- R6: If the trigger is high for fewer than HOLD_CYC cycles before it drops, the transfer is ignored.
- R7: Applying duty zero holds the output constant at its inactive level: 0 for normal polarity, 1 for inverted.
- R8: Active settings change only at a period boundary, and only after a completed handshake.
- R9: The polarity bit inverts the output, and a change to it takes effect only through the handshake.
- R10: A handshake on one channel does not alter any other channel's waveform.
- R11: After reset, all registers read zero and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| pwm_out | output | NCH | One waveform output per channel |

## Verification
A handshake can complete in the same clock as a period boundary. The load into the staging register and the staged-to-active transfer then fall in one cycle. In the disable state the boundary comes on every clock, so a channel brought up from zero settings always hits this collision. The bench provokes it by reprogramming a channel from the disable state and by random updates with short periods and small prescales. It then judges the outcome from the measured high and low run lengths, and the boundary assertion checks that the active settings only move at a boundary with an update pending.

// File: rtl/pwmtrig_pkg.sv
`timescale 1ns/1ps
package pwmtrig_pkg;

  localparam int CTRL_ADDR = 0;
  localparam int PS_ADDR   = 1;
  localparam int CHAN_BASE = 2;

  // minimum hold time in ns converted to whole clock cycles (rounded up)
  function automatic int hold_cycles(input int min_ns, input int clk_ps);
    return (min_ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int period_addr(input int ch);
    return CHAN_BASE + 2 * ch;
  endfunction

  function automatic int duty_addr(input int ch);
    return CHAN_BASE + 2 * ch + 1;
  endfunction

endpackage

// File: rtl/pwmtrig_regs.sv
`timescale 1ns/1ps
module pwmtrig_regs #(
  parameter int NCH    = 2,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [3*NCH-1:0]           ctrl_q,
  output logic [NCH*PS_W-1:0]        ps_q,
  output logic [NCH-1:0][CNT_W-1:0]  period_q,
  output logic [NCH-1:0][CNT_W-1:0]  duty_q
);
  import pwmtrig_pkg::*;

  localparam int CTRL_W = 3 * NCH;
  localparam int PSR_W  = NCH * PS_W;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ps_q     <= '0;
      period_q <= '0;
      duty_q   <= '0;
    end else if (bus_wr) begin
      if (hit(bus_addr, CTRL_ADDR)) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (hit(bus_addr, PS_ADDR))   ps_q   <= bus_wdata[PSR_W-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (hit(bus_addr, period_addr(c))) period_q[c] <= bus_wdata[CNT_W-1:0];
        if (hit(bus_addr, duty_addr(c)))   duty_q[c]   <= bus_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, CTRL_ADDR)) bus_rdata[CTRL_W-1:0] = ctrl_q;
    if (hit(bus_addr, PS_ADDR))   bus_rdata[PSR_W-1:0]  = ps_q;
    for (int c = 0; c < NCH; c++) begin
      if (hit(bus_addr, period_addr(c))) bus_rdata[CNT_W-1:0] = period_q[c];
      if (hit(bus_addr, duty_addr(c)))   bus_rdata[CNT_W-1:0] = duty_q[c];
    end
  end

  // R1: a write lands in the addressed control register on the next cycle
  assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(CTRL_ADDR)) |=> ctrl_q == $past(bus_wdata[CTRL_W-1:0]));

endmodule

// File: rtl/pwmtrig_handshake.sv
`timescale 1ns/1ps
module pwmtrig_handshake #(
  parameter int HOLD_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic smooth,
  output logic xfer_done
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          trig_q;
  logic [CW-1:0] low_cnt;
  logic [CW-1:0] high_cnt;
  logic          armed;

  // named internal events
  logic          rise;
  logic          gap_ok;
  logic          short_gap;
  logic          arm_now;
  logic [CW-1:0] seen;
  logic          fire;

  assign rise      = trig & ~trig_q;
  assign gap_ok    = low_cnt >= CW'(HOLD_CYC);
  assign short_gap = rise & ~gap_ok;
  assign arm_now   = rise ? (gap_ok & ~smooth) : (armed & trig & ~smooth);
  assign seen      = rise ? CW'(1) : high_cnt + 1'b1;
  assign fire      = arm_now && (seen >= CW'(HOLD_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q    <= 1'b0;
      low_cnt   <= '0;
      high_cnt  <= '0;
      armed     <= 1'b0;
      xfer_done <= 1'b0;
    end else begin
      trig_q <= trig;
      if (!trig) low_cnt <= gap_ok ? low_cnt : low_cnt + 1'b1;
      else       low_cnt <= '0;
      armed     <= arm_now & ~fire;
      high_cnt  <= arm_now ? seen : '0;
      xfer_done <= fire;
    end
  end

  // R4: an early rising edge never arms and never completes
  assert_short_gap_rejected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    short_gap |=> (!armed && !xfer_done));

  // R5: completion only follows a trigger sampled high with smooth clear
  assert_done_needs_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(trig && !smooth));

  generate
    if (HOLD_CYC > 1) begin : g_hold_chk
      // R6: the trigger was already high one cycle before the completing sample
      assert_high_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $past(trig, 2));
    end
  endgenerate

endmodule

// File: rtl/pwmtrig_channel.sv
`timescale 1ns/1ps
module pwmtrig_channel #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] sh_period,
  input  logic [CNT_W-1:0] sh_duty,
  input  logic [PS_W-1:0]  sh_ps,
  input  logic             sh_pol,
  output logic             pwm_out
);
  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
    logic [PS_W-1:0]  ps;
    logic             pol;
  } wave_cfg_t;

  wave_cfg_t        staged, active;
  logic             pending;
  logic [PS_W-1:0]  ps_cnt;
  logic [CNT_W-1:0] cnt;

  logic tick;
  logic last;
  logic boundary;
  logic take;

  function automatic logic is_last(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return (p == '0) || (c == p - 1'b1);
  endfunction

  function automatic logic level(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] d,
                                 input logic pol);
    return (c < d) ^ pol;
  endfunction

  assign tick     = ps_cnt == active.ps;
  assign last     = is_last(cnt, active.period);
  assign boundary = tick & last;
  assign take     = boundary & pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged  <= '0;
      active  <= '0;
      pending <= 1'b0;
      ps_cnt  <= '0;
      cnt     <= '0;
      pwm_out <= 1'b0;
    end else begin
      if (load) begin
        staged.period <= sh_period;
        staged.duty   <= sh_duty;
        staged.ps     <= sh_ps;
        staged.pol    <= sh_pol;
      end
      pending <= load | (pending & ~boundary);
      if (take) active <= staged;
      ps_cnt <= tick ? '0 : ps_cnt + 1'b1;
      if (tick) cnt <= last ? '0 : cnt + 1'b1;
      pwm_out <= level(cnt, active.duty, active.pol);
    end
  end

  // R8: the live settings move only at a boundary with an update pending
  assert_active_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(active.period) || !$stable(active.duty) || !$stable(active.ps))
      |-> $past(boundary && pending));

  // R9: polarity changes only through a staged update
  assert_pol_only_by_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active.pol) |-> $past(pending));

  // R3: the period counter stays inside the active period
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active.period != '0) |-> (cnt < active.period));

  // R7: zero duty yields the inactive level on the next cycle
  assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active.duty == '0) |=> (pwm_out == $past(active.pol)));

endmodule

// File: rtl/pwm_trig_multi.sv
`timescale 1ns/1ps
module pwm_trig_multi #(
  parameter int NCH           = 2,
  parameter int CNT_W         = 16,
  parameter int PS_W          = 4,
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 4,
  parameter int CLK_PERIOD_PS = 4000,
  parameter int MIN_HOLD_NS   = 400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int HOLD_CYC = pwmtrig_pkg::hold_cycles(MIN_HOLD_NS, CLK_PERIOD_PS);

  logic [3*NCH-1:0]          ctrl_q;
  logic [NCH*PS_W-1:0]       ps_q;
  logic [NCH-1:0][CNT_W-1:0] period_q;
  logic [NCH-1:0][CNT_W-1:0] duty_q;
  logic [NCH-1:0]            xfer_done;

  pwmtrig_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .PS_W(PS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_q(ctrl_q),
    .ps_q(ps_q), .period_q(period_q), .duty_q(duty_q)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      pwmtrig_handshake #(.HOLD_CYC(HOLD_CYC)) u_hs (
        .clk(clk), .rst_n(rst_n),
        .trig(ctrl_q[c]), .smooth(ctrl_q[NCH + c]),
        .xfer_done(xfer_done[c])
      );

      pwmtrig_channel #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .load(xfer_done[c]),
        .sh_period(period_q[c]), .sh_duty(duty_q[c]),
        .sh_ps(ps_q[c*PS_W +: PS_W]), .sh_pol(ctrl_q[2*NCH + c]),
        .pwm_out(pwm_out[c])
      );
    end
  endgenerate

  // R11: nothing is driven active straight out of reset
  assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pwm_out == '0));

endmodule

// File: tb/pwm_trig_multi_bench.sv
`timescale 1ns/1ps
module pwm_trig_multi_bench;
  localparam int NCH = 2;
  localparam int PS_W = 4;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [NCH-1:0]    pwm_out;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [3*NCH-1:0]    ctrl_img = '0;
  logic [NCH*PS_W-1:0] ps_img = '0;

  pwm_trig_multi u_pwm_trig_multi (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #2 clk = ~clk;

  function automatic int exp_hi(int p, int d, int s, int pol);
    int m = (d < p) ? d : p;
    return pol ? (p - m) * (s + 1) : m * (s + 1);
  endfunction

  function automatic int exp_lo(int p, int d, int s, int pol);
    int m = (d < p) ? d : p;
    return pol ? m * (s + 1) : (p - m) * (s + 1);
  endfunction

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_addr = ADDR_W'(a);
    #1 d = int'(bus_rdata);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog(input int ch, input int p, input int d, input int s);
    wr(2 + 2*ch, p);
    wr(3 + 2*ch, d);
    ps_img[ch*PS_W +: PS_W] = PS_W'(s);
    wr(1, int'(ps_img));
  endtask

  task automatic set_pol(input int ch, input int pol);
    ctrl_img[2*NCH + ch] = pol[0];
    wr(0, int'(ctrl_img));
  endtask

  // raise trigger (with chosen smooth) for hi cycles, then park low with smooth set
  task automatic pulse(input int ch, input int smooth, input int hi);
    ctrl_img[ch] = 1'b1; ctrl_img[NCH + ch] = smooth[0];
    wr(0, int'(ctrl_img));
    wait_cyc(hi);
    ctrl_img[ch] = 1'b0; ctrl_img[NCH + ch] = 1'b1;
    wr(0, int'(ctrl_img));
  endtask

  task automatic apply(input int ch, input int gap, input int hi);
    ctrl_img[ch] = 1'b0; ctrl_img[NCH + ch] = 1'b1;
    wr(0, int'(ctrl_img));
    wait_cyc(gap);
    pulse(ch, 0, hi);
  endtask

  task automatic measure(input int ch, output int hi, output int lo);
    int guard;
    logic prev, cur;
    hi = 0; lo = 0; guard = 0;
    @(negedge clk); prev = pwm_out[ch];
    while (guard < 2000) begin
      @(negedge clk); cur = pwm_out[ch]; guard++;
      if (!prev && cur) break;
      prev = cur;
    end
    if (guard >= 2000) return;
    hi = 1;
    while (hi < 2000) begin
      @(negedge clk);
      if (!pwm_out[ch]) break;
      hi++;
    end
    lo = 1;
    while (lo < 2000) begin
      @(negedge clk);
      if (pwm_out[ch]) break;
      lo++;
    end
  endtask

  task automatic check_wave(input string req, input int ch, input int p, input int d,
                            input int s, input int pol);
    int hi, lo;
    measure(ch, hi, lo);
    check({req, " high run"}, hi, exp_hi(p, d, s, pol));
    check({req, " low run"}, lo, exp_lo(p, d, s, pol));
  endtask

  task automatic check_const(input string req, input int ch, input int lvl, input int n);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch] != lvl[0]) bad++;
    end
    check(req, bad, 0);
  endtask

  initial begin
    int v, seed, p, d, s, pol, ch;
    seed = $urandom(32'h00C0FFEE);
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);

    // R11: reset state
    check("R11 outputs after reset", int'(pwm_out), 0);
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      check("R11 register after reset", v, 0);
    end

    // R1: readback of every register, unused address reads zero
    wr(2, 16'h1234); rd(2, v); check("R1 period0 readback", v, 16'h1234);
    wr(5, 16'h00A5); rd(5, v); check("R1 duty1 readback", v, 16'h00A5);
    wr(1, 8'h7C);    rd(1, v); check("R1 prescale readback", v, 8'h7C);
    ctrl_img = 6'b111100;
    wr(0, int'(ctrl_img)); rd(0, v); check("R1 control readback", v, 6'b111100);
    rd(9, v); check("R1 unused address", v, 0);
    ctrl_img = 6'b001100; ps_img = '0;
    wr(0, int'(ctrl_img));

    // R2 R3 R10: two channels, different prescale fields
    prog(0, 10, 3, 1);
    prog(1, 8, 6, 2);
    apply(0, 120, 110);
    apply(1, 120, 110);
    wait_cyc(200);
    check_wave("R3 ch0 basic", 0, 10, 3, 1, 0);
    check_wave("R2 ch1 own prescale field", 1, 8, 6, 2, 0);

    // R5: shadow writes with trigger low leave the waveform alone
    prog(0, 12, 9, 0);
    wait_cyc(200);
    check_wave("R5 smooth hold", 0, 10, 3, 1, 0);

    // R5: trigger pulse with smooth set does not transfer
    pulse(0, 1, 110);
    wait_cyc(200);
    check_wave("R5 trigger with smooth set", 0, 10, 3, 1, 0);

    // R4: re-raise after a short low gap
    pulse(0, 1, 10);
    wait_cyc(30);
    pulse(0, 0, 110);
    wait_cyc(200);
    check_wave("R4 short gap ignored", 0, 10, 3, 1, 0);

    // R6: high phase too short
    wait_cyc(150);
    pulse(0, 0, 60);
    wait_cyc(200);
    check_wave("R6 short high ignored", 0, 10, 3, 1, 0);

    // R8 R10: valid update reaches ch0 at a boundary, ch1 untouched
    apply(0, 120, 110);
    wait_cyc(200);
    check_wave("R8 valid update", 0, 12, 9, 0, 0);
    check_wave("R10 other channel unchanged", 1, 8, 6, 2, 0);

    // R9: polarity waits for the handshake, then inverts
    set_pol(0, 1);
    wait_cyc(200);
    check_wave("R9 polarity not yet applied", 0, 12, 9, 0, 0);
    apply(0, 120, 110);
    wait_cyc(200);
    check_wave("R9 polarity applied", 0, 12, 9, 0, 1);

    // R3: duty at or above period keeps the output high
    prog(1, 5, 7, 0);
    apply(1, 120, 110);
    wait_cyc(100);
    check_const("R3 duty above period", 1, 1, 200);

    // R7: disable state, normal then inverted polarity
    prog(1, 0, 0, 0);
    apply(1, 120, 110);
    wait_cyc(50);
    check_const("R7 disabled normal", 1, 0, 300);
    set_pol(1, 1);
    apply(1, 120, 110);
    wait_cyc(50);
    check_const("R7 disabled inverted", 1, 1, 300);

    // R3 R9: random updates, including from the disable state (boundary every cycle)
    for (int it = 0; it < 8; it++) begin
      ch  = int'($urandom % NCH);
      p   = 3 + int'($urandom % 18);
      d   = 1 + int'($urandom % (p - 1));
      s   = int'($urandom % 4);
      pol = int'($urandom % 2);
      prog(ch, p, d, s);
      set_pol(ch, pol);
      apply(ch, 120, 110);
      wait_cyc(200);
      check_wave("R3 random update", ch, p, d, s, pol);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule